// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block turns a stream of clock enables running at prescaler-input rate into one comparison pulse for every P·N + A enables. A built-in behavioural model of a dual-modulus P/(P+1) prescaler sits on the enable stream. A main counter of N and a swallow counter of A count the prescaler's output periods. While the swallow count is nonzero, the modulus-control output keeps the prescaler at P+1. Once it reaches zero, the rest of the N periods run at P. The main count N, the swallow count A and the modulus select are the settings.

A channel-type parameter picks which pair of base moduli applies. The low-band variant uses 16 or 32. The high-band variant uses 64 or 128. The modulus select input chooses the smaller value when high. A power-save input parks both counters in reload and keeps every output quiet. The settings are taken only at the boundary of a full division cycle, so a controller may rewrite them at any time.

Top module: `swallow_div`

## Requirements
- R1: `fp_o` is a single-clock pulse that occurs once every P·N + A counted enables. With the low-band channel and `sw_i` = 1, P = 16.
- R2: With the low-band channel and `sw_i` = 0, P = 32.
- R3: With the high-band channel (`CHAN` = CHAN_RF), `sw_i` = 1 gives P = 64 and `sw_i` = 0 gives P = 128.
- R4: `mod_o` is high for exactly the first A·(P+1) enables of each cycle, which are the first A prescaler periods, and low for all the rest. It is low on the enable that completes a cycle.
- R5: With A = 0, `mod_o` never rises and the ratio is P·N.
- R6: A = N−1 and A = 127, the largest swallow values, give the exact ratio P·N + A.
- R7: `n_i`, `a_i` and `sw_i` are captured only on the clock edge where a cycle completes. A change in the middle of a cycle leaves that cycle's length unchanged and applies to the following one.
- R8: Only clocks with `vco_en_i` high advance the divider. Idle clocks in between do not change the ratio counted in enables.
- R9: While `ps_i` is high, from the next clock on `fp_o`, `mod_o` and `pre_o` are low and the counters reload from the settings. The first clock after `ps_i` falls is a setup clock, and any enable on it is ignored. Counting then starts a fresh cycle of exactly P·N + A enables using the settings present at release.
- R10: While `rst_ni` is low, `fp_o`, `mod_o` and `pre_o` are low. Leaving reset behaves like leaving power save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vco_en_i | input | 1 | One enable per prescaler input period |
| ps_i | input | 1 | Power save: hold in reload, outputs quiet |
| sw_i | input | 1 | Modulus select: 1 picks the smaller base modulus |
| n_i | input | N_W | Main count N, 5 to 2047 |
| a_i | input | A_W | Swallow count A, 0 to 127, less than N |
| mod_o | output | 1 | Modulus control: 1 selects P+1 |
| pre_o | output | 1 | Prescaler model output, one pulse per prescaler period |
| fp_o | output | 1 | Comparison pulse, once per full cycle |

## Verification
The bound checker watches five things on every clock. It checks that the comparison pulse is one clock wide. It checks that the pulse always follows a prescaler output pulse. It checks that modulus control is already low when a cycle ends. It checks that modulus control only falls after a prescaler pulse or a power-save request. It checks that power save silences the outputs from the next clock on. The exact counts cannot be expressed as single-cycle properties: the ratio P·N + A, the leading A·(P+1) enables with modulus control high, and the boundary-only capture of settings. The bench's scenarios show these by counting enables between pulses. Those scenarios cover both modulus choices on both channel variants, gapped enable streams, and restarts after power save.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;

    typedef enum logic {
        CHAN_IF = 1'b0,
        CHAN_RF = 1'b1
    } chan_e;

    // Base prescaler modulus P for a channel variant and modulus select.
    function automatic int unsigned base_mod(chan_e ch, logic sel_small);
        if (ch == CHAN_RF) return sel_small ? 64 : 128;
        return sel_small ? 16 : 32;
    endfunction

    // Largest modulus the prescaler model ever runs at (P+1 of the big base).
    function automatic int unsigned max_mod(chan_e ch);
        return base_mod(ch, 1'b0) + 1;
    endfunction

endpackage

// File: rtl/swallow_div_presc.sv
module swallow_div_presc
    import swallow_div_pkg::*;
#(
    parameter chan_e CHAN = CHAN_IF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hold_i,
    input  logic en_i,
    input  logic sw_i,
    input  logic mod_i,
    output logic tick_o
);
    localparam int unsigned PC_W     = $clog2(max_mod(CHAN) + 1);
    localparam int unsigned P_SMALL  = base_mod(CHAN, 1'b1);
    localparam int unsigned P_LARGE  = base_mod(CHAN, 1'b0);

    typedef struct packed {
        logic [PC_W-1:0] cnt;
    } presc_st_t;

    presc_st_t       st_d, st_q;
    logic [PC_W-1:0] last_idx;

    always_comb begin
        last_idx = (sw_i ? PC_W'(P_SMALL) : PC_W'(P_LARGE)) - PC_W'(1) + PC_W'(mod_i);
        tick_o   = !hold_i && en_i && (st_q.cnt == last_idx);
        st_d     = st_q;
        if (hold_i) begin
            st_d.cnt = '0;
        end else if (en_i) begin
            st_d.cnt = tick_o ? '0 : st_q.cnt + PC_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/swallow_div_cnt.sv
module swallow_div_cnt #(
    parameter int unsigned N_W = 11,
    parameter int unsigned A_W = 7
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           ps_i,
    input  logic           tick_i,
    input  logic [N_W-1:0] n_i,
    input  logic [A_W-1:0] a_i,
    input  logic           sw_i,
    output logic           run_o,
    output logic           sw_o,
    output logic           mod_o,
    output logic           fp_o
);
    typedef struct packed {
        logic           run;
        logic           sw;
        logic           fp;
        logic [N_W-1:0] main;
        logic [A_W-1:0] swal;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.fp = 1'b0;
        if (ps_i || !st_q.run) begin
            // parked or setting up: follow the settings
            st_d.run  = !ps_i;
            st_d.main = n_i;
            st_d.swal = a_i;
            st_d.sw   = sw_i;
        end else if (tick_i) begin
            if (st_q.main == N_W'(1)) begin
                // cycle boundary: capture new settings, emit pulse
                st_d.main = n_i;
                st_d.swal = a_i;
                st_d.sw   = sw_i;
                st_d.fp   = 1'b1;
            end else begin
                st_d.main = st_q.main - N_W'(1);
                if (st_q.swal != '0) st_d.swal = st_q.swal - A_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign run_o = st_q.run;
    assign sw_o  = st_q.sw;
    assign mod_o = st_q.run && (st_q.swal != '0);
    assign fp_o  = st_q.fp;

endmodule

// File: rtl/swallow_div.sv
module swallow_div
    import swallow_div_pkg::*;
#(
    parameter chan_e       CHAN = CHAN_IF,
    parameter int unsigned N_W  = 11,
    parameter int unsigned A_W  = 7
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           vco_en_i,
    input  logic           ps_i,
    input  logic           sw_i,
    input  logic [N_W-1:0] n_i,
    input  logic [A_W-1:0] a_i,
    output logic           mod_o,
    output logic           pre_o,
    output logic           fp_o
);
    logic run_w;
    logic sw_act_w;
    logic mod_w;
    logic tick_w;

    swallow_div_presc #(
        .CHAN (CHAN)
    ) presc_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hold_i (!run_w),
        .en_i   (vco_en_i),
        .sw_i   (sw_act_w),
        .mod_i  (mod_w),
        .tick_o (tick_w)
    );

    swallow_div_cnt #(
        .N_W (N_W),
        .A_W (A_W)
    ) cnt_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ps_i   (ps_i),
        .tick_i (tick_w),
        .n_i    (n_i),
        .a_i    (a_i),
        .sw_i   (sw_i),
        .run_o  (run_w),
        .sw_o   (sw_act_w),
        .mod_o  (mod_w),
        .fp_o   (fp_o)
    );

    assign mod_o = mod_w;
    assign pre_o = tick_w;

endmodule

// File: rtl/swallow_div_chk.sv
module swallow_div_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic ps_i,
    input logic mod_o,
    input logic pre_o,
    input logic fp_o
);
    // R1: comparison pulse lasts one clock
    p_fp_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fp_o |=> !fp_o);

    // R1: a cycle only ends on a prescaler output pulse
    p_fp_after_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fp_o |-> $past(pre_o));

    // R4: swallow phase is over before the cycle ends
    p_mod_low_at_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fp_o |-> !$past(mod_o));

    // R4: modulus control drops only after a prescaler pulse or power save
    p_mod_fall_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mod_o) |-> ($past(pre_o) || $past(ps_i)));

    // R9: power save silences pulse and modulus control from the next clock
    p_ps_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ps_i |=> (!fp_o && !mod_o));

endmodule

bind swallow_div swallow_div_chk chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ps_i   (ps_i),
    .mod_o  (mod_o),
    .pre_o  (pre_o),
    .fp_o   (fp_o)
);

// File: tb/swallow_div_tb_top.sv
`timescale 1ns/1ps
module swallow_div_tb_top;
    import swallow_div_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_if = 1'b0;
    logic        en_rf = 1'b0;
    logic        ps = 1'b0;
    logic        sw = 1'b1;
    logic [10:0] n = 11'd5;
    logic [6:0]  a = 7'd0;
    logic        mod_if, pre_if, fp_if;
    logic        mod_rf, pre_rf, fp_rf;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    swallow_div #(.CHAN(CHAN_IF)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .vco_en_i(en_if), .ps_i(ps), .sw_i(sw),
        .n_i(n), .a_i(a), .mod_o(mod_if), .pre_o(pre_if), .fp_o(fp_if));

    swallow_div #(.CHAN(CHAN_RF)) dut_rf_i (
        .clk_i(clk), .rst_ni(rst_n), .vco_en_i(en_rf), .ps_i(ps), .sw_i(sw),
        .n_i(n), .a_i(a), .mod_o(mod_rf), .pre_o(pre_rf), .fp_o(fp_rf));

    // sw, n, a, idle clocks between enables
    localparam int VEC [8][4] = '{
        '{1,    5,   0, 0},
        '{1,    5,   4, 0},
        '{0,    7,   3, 0},
        '{1,   20,  19, 1},
        '{0,    9,   0, 2},
        '{1,  130, 127, 0},
        '{0,    6,   5, 0},
        '{1, 2047, 100, 0}
    };

    function automatic int p_of(bit rf, bit s);
        if (rf) return s ? 64 : 128;
        return s ? 16 : 32;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive enables until the chosen divider pulses; report enables and mod-high enables.
    task automatic run_cycle(input bit rf, input int gap, output int cnt, output int mcnt,
                             output bit lead);
        int  cyc = 0;
        bit  low_seen = 1'b0;
        bit  done = 1'b0;
        bit  fpv, modv, env;
        cnt = 0; mcnt = 0; lead = 1'b1;
        while (!done) begin
            @(negedge clk);
            fpv  = rf ? fp_rf : fp_if;
            modv = rf ? mod_rf : mod_if;
            if (fpv) begin
                en_if = 1'b0; en_rf = 1'b0; done = 1'b1;
            end else if (cyc > 70000) begin
                en_if = 1'b0; en_rf = 1'b0; cnt = -1; done = 1'b1;
            end else begin
                env   = (gap == 0) || (cyc % (gap + 1) == 0);
                en_if = env && !rf;
                en_rf = env && rf;
                if (env) begin
                    cnt++;
                    if (modv) begin
                        mcnt++;
                        if (low_seen) lead = 1'b0;
                    end else begin
                        low_seen = 1'b1;
                    end
                end
                cyc++;
            end
        end
    endtask

    task automatic park_and_release(input bit s, input int nv, input int av);
        @(negedge clk);
        ps = 1'b1; en_if = 1'b1; en_rf = 1'b1;
        sw = s; n = 11'(nv); a = 7'(av);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(!fp_if && !mod_if && !pre_if, "R9 IF quiet in power save",
                int'({fp_if, mod_if, pre_if}), 0);
            chk(!fp_rf && !mod_rf && !pre_rf, "R9 RF quiet in power save",
                int'({fp_rf, mod_rf, pre_rf}), 0);
        end
        ps = 1'b0; en_if = 1'b0; en_rf = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        int  cnt, mcnt, prev_ratio, ratio, p;
        bit  lead;
        string tag;

        // R10: reset state
        sw = 1'(VEC[0][0]); n = 11'(VEC[0][1]); a = 7'(VEC[0][2]);
        en_if = 1'b1; en_rf = 1'b1;
        repeat (3) @(negedge clk);
        chk(!fp_if && !mod_if && !pre_if, "R10 IF outputs in reset",
            int'({fp_if, mod_if, pre_if}), 0);
        chk(!fp_rf && !mod_rf && !pre_rf, "R10 RF outputs in reset",
            int'({fp_rf, mod_rf, pre_rf}), 0);
        en_if = 1'b0; en_rf = 1'b0;
        rst_n = 1'b1;

        // R10: first cycle after reset uses the settings present at release
        prev_ratio = p_of(1'b0, 1'(VEC[0][0])) * VEC[0][1] + VEC[0][2];
        run_cycle(1'b0, 0, cnt, mcnt, lead);
        chk(cnt == prev_ratio, "R10 first cycle after reset", cnt, prev_ratio);

        // table walk: each row checked on the carried-over cycle (R7) and its own cycle
        for (int i = 0; i < 8; i++) begin
            sw = 1'(VEC[i][0]); n = 11'(VEC[i][1]); a = 7'(VEC[i][2]);
            run_cycle(1'b0, VEC[i][3], cnt, mcnt, lead);
            chk(cnt == prev_ratio, "R7 settings held until boundary", cnt, prev_ratio);
            p     = p_of(1'b0, 1'(VEC[i][0]));
            ratio = p * VEC[i][1] + VEC[i][2];
            run_cycle(1'b0, VEC[i][3], cnt, mcnt, lead);
            if (VEC[i][3] != 0)                tag = "R8 gapped enables ratio";
            else if (VEC[i][2] == 0)           tag = "R5 zero swallow ratio";
            else if (VEC[i][2] == VEC[i][1]-1 || VEC[i][2] == 127) tag = "R6 max swallow ratio";
            else if (VEC[i][0] != 0)           tag = "R1 P=16 ratio";
            else                               tag = "R2 P=32 ratio";
            chk(cnt == ratio, tag, cnt, ratio);
            chk(mcnt == VEC[i][2] * (p + 1), "R4 mod-high enable count", mcnt,
                VEC[i][2] * (p + 1));
            chk(lead, "R4 mod-high enables lead the cycle", int'(lead), 1);
            prev_ratio = ratio;
        end

        // R9: power save mid-cycle, restart with new settings
        park_and_release(1'b0, 8, 2);
        run_cycle(1'b0, 0, cnt, mcnt, lead);
        chk(cnt == 32 * 8 + 2, "R9 full cycle after power save", cnt, 32 * 8 + 2);
        chk(mcnt == 2 * 33, "R9 mod-high count after power save", mcnt, 2 * 33);

        // R3: high-band variant, both moduli
        park_and_release(1'b1, 5, 4);
        run_cycle(1'b1, 0, cnt, mcnt, lead);
        chk(cnt == 64 * 5 + 4, "R3 P=64 ratio", cnt, 64 * 5 + 4);
        chk(mcnt == 4 * 65, "R3 P=64 mod-high count", mcnt, 4 * 65);
        sw = 1'b0; n = 11'd6; a = 7'd5;
        run_cycle(1'b1, 0, cnt, mcnt, lead);
        chk(cnt == 64 * 5 + 4, "R7 RF settings held until boundary", cnt, 64 * 5 + 4);
        run_cycle(1'b1, 0, cnt, mcnt, lead);
        chk(cnt == 128 * 6 + 5, "R3 P=128 ratio", cnt, 128 * 6 + 5);
        chk(mcnt == 5 * 129, "R3 P=128 mod-high count", mcnt, 5 * 129);
        chk(lead, "R3 mod-high enables lead the cycle", int'(lead), 1);

        // R8: idle clocks alone never advance the divider
        repeat (50) begin
            @(negedge clk);
            chk(!fp_rf && !pre_rf, "R8 no activity without enables",
                int'({fp_rf, pre_rf}), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule